// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating Controller

This block decides, cycle by cycle, which clocks in a subsystem may run. It follows three power modes: Run, Sleep and Deep-Sleep. Software asks for a sleep mode with a request pulse that carries a deep flag. A wake interrupt brings the block back to Run. Each mode has its own set of per-peripheral gating bits. The Sleep and Deep-Sleep sets apply only while automatic gating is enabled; otherwise the Run set stays in force. A build-time presence mask limits which gating bits can ever hold a one.

On Deep-Sleep entry the block stores the Run clock source and divider in shadow registers. It then moves the system clock to a low-power oscillator. If the PLL was the source, it powers the PLL down and forces a fixed divider of 16 or 64. On wake it powers the stored source back up and waits a configurable settle count. It then restores the stored source and divider for one cycle while the core is still stopped. Only after that does it re-open the core and the Run gating set. The dividers and oscillators themselves sit outside this block.

Top module: `pwr_clk_gate`

## Requirements
- R1: A write with regWrSel 0, 1 or 2 loads the Run, Sleep or Deep-Sleep gating set with regWrData ANDed with PRESENT_MASK, effective from the next cycle. regWrSel 3 changes nothing. Bits outside PRESENT_MASK never appear on periphClkEn.
- R2: After reset the block is in Run with coreClkEn high, all gating sets zero and periphClkEn zero.
- R3: In Run, coreClkEn is 1, periphClkEn equals the Run set, and clkSrcSel and sysDiv follow runSrcSel and runDiv. Source codes: 0 main oscillator, 1 internal oscillator, 2 PLL. pllPowerDown is 1 unless the source is 2. mainOscPowerDown and intOscPowerUp are 1 only for source 1.
- R4: In Run, sleepReq with sleepDeep 0 enters Sleep at the next edge. In Sleep, coreClkEn is 0 and periphClkEn is the Sleep set when autoGateEn is 1, or the Run set when it is 0. Source, divider and power controls stay as in Run.
- R5: In Run, sleepReq with sleepDeep 1 enters Deep-Sleep at the next edge. There, coreClkEn is 0 and periphClkEn is the Deep-Sleep set when autoGateEn is 1, or the Run set when it is 0.
- R6: In Deep-Sleep, pllPowerDown is 1. clkSrcSel is 1 with intOscPowerUp 1 and mainOscPowerDown 1 if dsUseIntOsc was 1 at entry. Otherwise clkSrcSel is 0 with both of those outputs at 0.
- R7: If runSrcSel was 2 at Deep-Sleep entry, sysDiv is 64 when dsDivSel64 was 1 at entry, else 16, and divOverride is 1. Otherwise sysDiv keeps the entry divider and divOverride is 0.
- R8: wakeIrq in Sleep returns to Run at the next edge. In Run, wakeIrq has no effect.
- R9: wakeIrq in Deep-Sleep starts a settle phase of SETTLE_CYCLES cycles. During it the deep clock and gating persist and the entry source's oscillator or PLL is powered. Next comes one restore cycle with the entry source and divider on clkSrcSel and sysDiv while coreClkEn stays 0. Run follows.
- R10: The restored source and divider are the values captured at Deep-Sleep entry, regardless of later changes on runSrcSel and runDiv.
- R11: sleepReq outside Run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Gating register write strobe |
| regWrSel | input | 2 | 0 Run set, 1 Sleep set, 2 Deep-Sleep set, 3 none |
| regWrData | input | NUM_PERIPH | Write data |
| sleepReq | input | 1 | Sleep request pulse |
| sleepDeep | input | 1 | Request is for Deep-Sleep |
| wakeIrq | input | 1 | Wake interrupt |
| autoGateEn | input | 1 | Use per-mode gating sets in sleep modes |
| dsUseIntOsc | input | 1 | Deep-Sleep runs from the internal oscillator |
| dsDivSel64 | input | 1 | PLL override divider is 64 instead of 16 |
| runSrcSel | input | 2 | Run clock source code |
| runDiv | input | DIV_W | Run system divider |
| coreClkEn | output | 1 | Core and memory clock enable |
| periphClkEn | output | NUM_PERIPH | Per-peripheral clock enables |
| clkSrcSel | output | 2 | Effective clock source code |
| sysDiv | output | DIV_W | Effective system divider |
| divOverride | output | 1 | Divider is forced by Deep-Sleep |
| pllPowerDown | output | 1 | PLL power-down |
| mainOscPowerDown | output | 1 | Main oscillator power-down |
| intOscPowerUp | output | 1 | Internal oscillator power-up |

## Verification
A mode register in the wrong state shows up at once on coreClkEn and on which gating set drives periphClkEn. It takes only one cycle at a mode boundary. Bad shadow capture stays hidden through Deep-Sleep while the PLL override is active. It shows up in the restore cycle as a wrong clkSrcSel or sysDiv. A settle counter that is off by one moves the rise of coreClkEn by a cycle after a Deep-Sleep wake. That shift is measured directly.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;

  typedef enum logic [2:0] {
    MODE_RUN     = 3'd0,
    MODE_SLEEP   = 3'd1,
    MODE_DEEP    = 3'd2,
    MODE_WAKE    = 3'd3,
    MODE_RESTORE = 3'd4
  } mode_e;

  localparam logic [1:0] SRC_MAIN = 2'd0;
  localparam logic [1:0] SRC_INT  = 2'd1;
  localparam logic [1:0] SRC_PLL  = 2'd2;

  localparam logic [1:0] SEL_RUN   = 2'd0;
  localparam logic [1:0] SEL_SLEEP = 2'd1;
  localparam logic [1:0] SEL_DEEP  = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureShadow; // latch run clock config at deep entry
    logic coreOn;        // core and memory clock allowed
    logic useSleepSet;   // sleep gating set eligible
    logic useDeepSet;    // deep gating set eligible
    logic deepClk;       // deep clock configuration active
    logic wakeClk;       // settle phase: deep clock, target powered
    logic restoreClk;    // shadow source and divider on outputs
  } strobe_t;

endpackage

// File: rtl/pmcg_ctrl.sv
module pmcg_ctrl
  import pmcg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepReq,
  input  logic    sleepDeep,
  input  logic    wakeIrq,
  output strobe_t strobes,
  output mode_e   curMode
);

  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  mode_e modeQ, modeD;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_RUN:     if (sleepReq) modeD = sleepDeep ? MODE_DEEP : MODE_SLEEP;
      MODE_SLEEP:   if (wakeIrq) modeD = MODE_RUN;
      MODE_DEEP:    if (wakeIrq) modeD = MODE_WAKE;
      MODE_WAKE:    if (settleCnt == CNT_LAST) modeD = MODE_RESTORE;
      MODE_RESTORE: modeD = MODE_RUN;
      default:      modeD = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_RUN;
      settleCnt <= '0;
    end else begin
      modeQ <= modeD;
      if (modeQ == MODE_WAKE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

  always_comb begin
    strobes               = '0;
    strobes.captureShadow = (modeQ == MODE_RUN) && sleepReq && sleepDeep;
    strobes.coreOn        = (modeQ == MODE_RUN);
    strobes.useSleepSet   = (modeQ == MODE_SLEEP);
    strobes.useDeepSet    = (modeQ == MODE_DEEP) || (modeQ == MODE_WAKE) ||
                            (modeQ == MODE_RESTORE);
    strobes.deepClk       = (modeQ == MODE_DEEP);
    strobes.wakeClk       = (modeQ == MODE_WAKE);
    strobes.restoreClk    = (modeQ == MODE_RESTORE);
  end

  assign curMode = modeQ;

endmodule

// File: rtl/pmcg_datapath.sv
module pmcg_datapath
  import pmcg_pkg::*;
#(
  parameter int                    NUM_PERIPH   = 8,
  parameter int                    DIV_W        = 7,
  parameter logic [NUM_PERIPH-1:0] PRESENT_MASK = 8'hB7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic                  regWrEn,
  input  logic [1:0]            regWrSel,
  input  logic [NUM_PERIPH-1:0] regWrData,
  input  logic                  autoGateEn,
  input  logic                  dsUseIntOsc,
  input  logic                  dsDivSel64,
  input  logic [1:0]            runSrcSel,
  input  logic [DIV_W-1:0]      runDiv,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic [1:0]            clkSrcSel,
  output logic [DIV_W-1:0]      sysDiv,
  output logic                  divOverride,
  output logic                  pllPowerDown,
  output logic                  mainOscPowerDown,
  output logic                  intOscPowerUp
);

  localparam logic [DIV_W-1:0] DIV16 = DIV_W'(16);
  localparam logic [DIV_W-1:0] DIV64 = DIV_W'(64);

  logic [NUM_PERIPH-1:0] runGate, slpGate, dpGate;
  logic wrRun, wrSlp, wrDp;

  assign wrRun = regWrEn && (regWrSel == SEL_RUN);
  assign wrSlp = regWrEn && (regWrSel == SEL_SLEEP);
  assign wrDp  = regWrEn && (regWrSel == SEL_DEEP);

  logic pickSleep, pickDeep;
  assign pickSleep = autoGateEn && strobes.useSleepSet;
  assign pickDeep  = autoGateEn && strobes.useDeepSet;

  // Per-peripheral gating bits; absent peripherals have no storage
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    if (PRESENT_MASK[i]) begin : g_present
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runGate[i] <= 1'b0;
          slpGate[i] <= 1'b0;
          dpGate[i]  <= 1'b0;
        end else begin
          if (wrRun) runGate[i] <= regWrData[i];
          if (wrSlp) slpGate[i] <= regWrData[i];
          if (wrDp)  dpGate[i]  <= regWrData[i];
        end
      end
    end else begin : g_absent
      assign runGate[i] = 1'b0;
      assign slpGate[i] = 1'b0;
      assign dpGate[i]  = 1'b0;
    end

    always_comb begin
      if (pickDeep)       periphClkEn[i] = dpGate[i];
      else if (pickSleep) periphClkEn[i] = slpGate[i];
      else                periphClkEn[i] = runGate[i];
    end
  end

  // Shadow of the run clock configuration taken at deep entry
  logic [1:0]       shSrc;
  logic [DIV_W-1:0] shDiv;
  logic             shInt, sh64;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shSrc <= SRC_MAIN;
      shDiv <= '0;
      shInt <= 1'b0;
      sh64  <= 1'b0;
    end else if (strobes.captureShadow) begin
      shSrc <= runSrcSel;
      shDiv <= runDiv;
      shInt <= dsUseIntOsc;
      sh64  <= dsDivSel64;
    end
  end

  logic             pllWasOn;
  logic [1:0]       deepSrc;
  logic [DIV_W-1:0] deepDiv;

  assign pllWasOn = (shSrc == SRC_PLL);
  assign deepSrc  = shInt ? SRC_INT : SRC_MAIN;
  assign deepDiv  = pllWasOn ? (sh64 ? DIV64 : DIV16) : shDiv;

  logic inDeepClk;
  assign inDeepClk = strobes.deepClk || strobes.wakeClk;

  always_comb begin
    if (inDeepClk) begin
      clkSrcSel   = deepSrc;
      sysDiv      = deepDiv;
      divOverride = pllWasOn;
    end else if (strobes.restoreClk) begin
      clkSrcSel   = shSrc;
      sysDiv      = shDiv;
      divOverride = 1'b0;
    end else begin
      clkSrcSel   = runSrcSel;
      sysDiv      = runDiv;
      divOverride = 1'b0;
    end
  end

  always_comb begin
    if (strobes.deepClk) begin
      pllPowerDown     = 1'b1;
      mainOscPowerDown = shInt;
      intOscPowerUp    = shInt;
    end else if (strobes.wakeClk) begin
      pllPowerDown     = !pllWasOn;
      mainOscPowerDown = shInt && (shSrc == SRC_INT);
      intOscPowerUp    = shInt || (shSrc == SRC_INT);
    end else begin
      pllPowerDown     = (clkSrcSel != SRC_PLL);
      mainOscPowerDown = (clkSrcSel == SRC_INT);
      intOscPowerUp    = (clkSrcSel == SRC_INT);
    end
  end

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pmcg_pkg::*;
#(
  parameter int                    NUM_PERIPH    = 8,
  parameter int                    DIV_W         = 7,
  parameter int                    SETTLE_CYCLES = 6,
  parameter logic [NUM_PERIPH-1:0] PRESENT_MASK  = 8'hB7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [1:0]            regWrSel,
  input  logic [NUM_PERIPH-1:0] regWrData,
  input  logic                  sleepReq,
  input  logic                  sleepDeep,
  input  logic                  wakeIrq,
  input  logic                  autoGateEn,
  input  logic                  dsUseIntOsc,
  input  logic                  dsDivSel64,
  input  logic [1:0]            runSrcSel,
  input  logic [DIV_W-1:0]      runDiv,
  output logic                  coreClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic [1:0]            clkSrcSel,
  output logic [DIV_W-1:0]      sysDiv,
  output logic                  divOverride,
  output logic                  pllPowerDown,
  output logic                  mainOscPowerDown,
  output logic                  intOscPowerUp
);

  strobe_t strobes;
  mode_e   curMode;

  pmcg_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .sleepDeep(sleepDeep),
    .wakeIrq  (wakeIrq),
    .strobes  (strobes),
    .curMode  (curMode)
  );

  pmcg_datapath #(
    .NUM_PERIPH  (NUM_PERIPH),
    .DIV_W       (DIV_W),
    .PRESENT_MASK(PRESENT_MASK)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .regWrEn         (regWrEn),
    .regWrSel        (regWrSel),
    .regWrData       (regWrData),
    .autoGateEn      (autoGateEn),
    .dsUseIntOsc     (dsUseIntOsc),
    .dsDivSel64      (dsDivSel64),
    .runSrcSel       (runSrcSel),
    .runDiv          (runDiv),
    .periphClkEn     (periphClkEn),
    .clkSrcSel       (clkSrcSel),
    .sysDiv          (sysDiv),
    .divOverride     (divOverride),
    .pllPowerDown    (pllPowerDown),
    .mainOscPowerDown(mainOscPowerDown),
    .intOscPowerUp   (intOscPowerUp)
  );

  assign coreClkEn = strobes.coreOn;

endmodule

// File: rtl/pmcg_checker.sv
module pmcg_checker
  import pmcg_pkg::*;
#(
  parameter int                    NUM_PERIPH   = 8,
  parameter int                    DIV_W        = 7,
  parameter logic [NUM_PERIPH-1:0] PRESENT_MASK = 8'hB7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sleepReq,
  input logic                  wakeIrq,
  input logic                  coreClkEn,
  input logic [NUM_PERIPH-1:0] periphClkEn,
  input logic [DIV_W-1:0]      sysDiv,
  input logic                  divOverride,
  input logic                  pllPowerDown,
  input mode_e                 curMode
);

  a_r1_mask_respected: assert property (@(posedge clk) disable iff (!rstN)
    (periphClkEn & ~PRESENT_MASK) == '0);

  a_r4_request_stops_core: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn && sleepReq) |=> !coreClkEn);

  a_r6_pll_down_in_deep: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_DEEP) |-> pllPowerDown);

  a_r7_override_values: assert property (@(posedge clk) disable iff (!rstN)
    divOverride |-> (sysDiv == DIV_W'(16) || sysDiv == DIV_W'(64)));

  a_r8_sleep_wake: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SLEEP && wakeIrq) |=> coreClkEn);

  a_r9_restore_core_off: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RESTORE) |-> (!coreClkEn && !divOverride));

  a_r9_restore_then_run: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RESTORE) |=> coreClkEn);

  a_r11_no_request_outside_run: assert property (@(posedge clk) disable iff (!rstN)
    (!coreClkEn && curMode != MODE_RESTORE && curMode != MODE_SLEEP && !wakeIrq)
      |=> !coreClkEn);

endmodule

bind pwr_clk_gate pmcg_checker #(
  .NUM_PERIPH  (NUM_PERIPH),
  .DIV_W       (DIV_W),
  .PRESENT_MASK(PRESENT_MASK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sleepReq   (sleepReq),
  .wakeIrq    (wakeIrq),
  .coreClkEn  (coreClkEn),
  .periphClkEn(periphClkEn),
  .sysDiv     (sysDiv),
  .divOverride(divOverride),
  .pllPowerDown(pllPowerDown),
  .curMode    (curMode)
);

// File: tb/tb_pwr_clk_gate.sv
`timescale 1ns/1ps
module tb_pwr_clk_gate;

  localparam int NP     = 8;
  localparam int DW     = 7;
  localparam int SETTLE = 6;
  localparam logic [NP-1:0] MASK = 8'hB7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0;
  logic [1:0] regWrSel = 0;
  logic [NP-1:0] regWrData = 0;
  logic sleepReq = 0, sleepDeep = 0, wakeIrq = 0;
  logic autoGateEn = 0, dsUseIntOsc = 0, dsDivSel64 = 0;
  logic [1:0] runSrcSel = 0;
  logic [DW-1:0] runDiv = 0;
  logic coreClkEn;
  logic [NP-1:0] periphClkEn;
  logic [1:0] clkSrcSel;
  logic [DW-1:0] sysDiv;
  logic divOverride, pllPowerDown, mainOscPowerDown, intOscPowerUp;

  always #5 clk = ~clk;

  pwr_clk_gate #(.NUM_PERIPH(NP), .DIV_W(DW), .SETTLE_CYCLES(SETTLE), .PRESENT_MASK(MASK)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .sleepReq(sleepReq), .sleepDeep(sleepDeep), .wakeIrq(wakeIrq), .autoGateEn(autoGateEn),
    .dsUseIntOsc(dsUseIntOsc), .dsDivSel64(dsDivSel64), .runSrcSel(runSrcSel), .runDiv(runDiv),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .clkSrcSel(clkSrcSel), .sysDiv(sysDiv),
    .divOverride(divOverride), .pllPowerDown(pllPowerDown),
    .mainOscPowerDown(mainOscPowerDown), .intOscPowerUp(intOscPowerUp));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Reference model: mode 0 run, 1 sleep, 2 deep, 3 settle, 4 restore
  int mM, cntM, runG, slpG, dpG, shSrc, shDiv, shInt, sh64;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mM <= 0; cntM <= 0; runG <= 0; slpG <= 0; dpG <= 0;
      shSrc <= 0; shDiv <= 0; shInt <= 0; sh64 <= 0;
    end else begin
      if (regWrEn) begin
        if (regWrSel == 0) runG <= int'(regWrData & MASK);
        if (regWrSel == 1) slpG <= int'(regWrData & MASK);
        if (regWrSel == 2) dpG  <= int'(regWrData & MASK);
      end
      if (mM == 0) begin
        if (sleepReq) begin
          mM <= sleepDeep ? 2 : 1;
          if (sleepDeep) begin
            shSrc <= int'(runSrcSel); shDiv <= int'(runDiv);
            shInt <= int'(dsUseIntOsc); sh64 <= int'(dsDivSel64);
          end
        end
      end else if (mM == 1) begin
        if (wakeIrq) mM <= 0;
      end else if (mM == 2) begin
        if (wakeIrq) begin mM <= 3; cntM <= 0; end
      end else if (mM == 3) begin
        if (cntM == SETTLE - 1) mM <= 4;
        else cntM <= cntM + 1;
      end else begin
        mM <= 0;
      end
    end
  end

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      int eSrc, eDiv, eOvr, ePer, ePll, eMain, eInt, s;
      string tCore, tPer, tClk, tPwr;
      s = (mM == 4) ? shSrc : int'(runSrcSel);
      if (mM <= 1) begin eSrc = int'(runSrcSel); eDiv = int'(runDiv); end
      else if (mM == 4) begin eSrc = shSrc; eDiv = shDiv; end
      else begin
        eSrc = shInt ? 1 : 0;
        eDiv = (shSrc == 2) ? (sh64 ? 64 : 16) : shDiv;
      end
      eOvr = ((mM == 2 || mM == 3) && shSrc == 2) ? 1 : 0;
      if (mM == 0) ePer = runG;
      else if (mM == 1) ePer = autoGateEn ? slpG : runG;
      else ePer = autoGateEn ? dpG : runG;
      if (mM == 2) begin ePll = 1; eMain = shInt; eInt = shInt; end
      else if (mM == 3) begin
        ePll = (shSrc != 2); eMain = (shInt && shSrc == 1); eInt = (shInt || shSrc == 1);
      end else begin
        ePll = (s != 2); eMain = (s == 1); eInt = (s == 1);
      end
      tCore = (mM == 0) ? "R3" : (mM == 1) ? "R4" : "R5";
      tPer  = (mM == 0) ? "R1" : (mM == 1) ? "R4" : "R5";
      tClk  = (mM == 4) ? "R10" : (mM >= 2) ? "R7" : "R3";
      tPwr  = (mM >= 3) ? "R9" : (mM == 2) ? "R6" : "R3";
      chk(tCore, int'(coreClkEn), (mM == 0) ? 1 : 0);
      chk(tPer, int'(periphClkEn), ePer);
      chk(tClk, int'(clkSrcSel), eSrc);
      chk(tClk, int'(sysDiv), eDiv);
      chk("R7", int'(divOverride), eOvr);
      chk(tPwr, int'(pllPowerDown), ePll);
      chk(tPwr, int'(mainOscPowerDown), eMain);
      chk(tPwr, int'(intOscPowerUp), eInt);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [NP-1:0] d);
    regWrEn = 1; regWrSel = sel; regWrData = d;
    step(1);
    regWrEn = 0;
  endtask

  task automatic req(input logic deep);
    sleepReq = 1; sleepDeep = deep;
    step(1);
    sleepReq = 0; sleepDeep = 0;
  endtask

  task automatic deepWake(input string tag);
    int n;
    wakeIrq = 1;
    step(1);
    wakeIrq = 0;
    n = 0;
    while (!coreClkEn && n < 100) begin step(1); n++; end
    chk(tag, n, SETTLE + 1); // R9 settle plus restore cycle
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    // R2 reset state
    chk("R2", int'(coreClkEn), 1);
    chk("R2", int'(periphClkEn), 0);
    rstN = 1;
    step(2);
    chk("R2", int'(periphClkEn), 0);

    // R1 masked writes and ignored select 3
    runSrcSel = 0; runDiv = 4;
    wr(2'd0, 8'hFF);
    chk("R1", int'(periphClkEn), int'(MASK));
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h38);
    wr(2'd3, 8'h00);
    chk("R1", int'(periphClkEn), int'(MASK));

    // R8 wake in run ignored
    wakeIrq = 1; step(1); wakeIrq = 0;
    chk("R8", int'(coreClkEn), 1);

    // R4 sleep with auto gating
    autoGateEn = 1;
    req(1'b0);
    chk("R4", int'(periphClkEn), int'(8'h0F & MASK));
    step(2);
    req(1'b1); // R11 ignored in sleep
    chk("R11", int'(coreClkEn), 0);
    wakeIrq = 1; step(1); wakeIrq = 0;
    chk("R8", int'(coreClkEn), 1);

    // R4 sleep without auto gating
    autoGateEn = 0; runSrcSel = 1; runDiv = 9;
    req(1'b0);
    chk("R4", int'(periphClkEn), int'(MASK));
    step(1);
    wakeIrq = 1; step(1); wakeIrq = 0;

    // R5 R6 R7 R9 R10 PLL deep, internal osc, /16
    autoGateEn = 1; runSrcSel = 2; runDiv = 3; dsUseIntOsc = 1; dsDivSel64 = 0;
    req(1'b1);
    chk("R7", int'(sysDiv), 16);
    chk("R6", int'(clkSrcSel), 1);
    runSrcSel = 0; runDiv = 11; // R10 live change during deep
    wr(2'd2, 8'hF0);
    step(3);
    req(1'b0); // R11
    chk("R11", int'(coreClkEn), 0);
    deepWake("R9");
    runSrcSel = 2; runDiv = 3;
    step(2);

    // R7 /64 from main oscillator
    dsUseIntOsc = 0; dsDivSel64 = 1;
    req(1'b1);
    chk("R7", int'(sysDiv), 64);
    chk("R6", int'(mainOscPowerDown), 0);
    step(2);
    deepWake("R9");
    step(2);

    // R7 no override when PLL not in use; R5 auto off
    autoGateEn = 0; runSrcSel = 1; runDiv = 5; dsUseIntOsc = 1;
    req(1'b1);
    chk("R7", int'(divOverride), 0);
    chk("R5", int'(periphClkEn), int'(MASK));
    step(2);
    autoGateEn = 1;
    step(1);
    deepWake("R9");

    // sleep request and wake in the same cycle in run
    sleepReq = 1; wakeIrq = 1; step(1); sleepReq = 0; wakeIrq = 0;
    chk("R4", int'(coreClkEn), 0);
    wakeIrq = 1; step(1); wakeIrq = 0;
    step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule